// File: doc/BRIEF.md
# Predicated After-Last Element Extractor

This unit takes a vector operand, a per-byte predicate and a 64-bit scalar operand. It finds the highest-numbered element that the predicate marks active, then returns the element one position above it. The scan is circular, so the last element is followed by element zero. The returned element is zero-extended to 64 bits. When the predicate marks no element active, the unit returns the scalar operand, cut down to the element width and zero-extended.

The scalar operand and the result represent the same architectural register. The surrounding pipeline writes the result back over the scalar operand. A 2-bit size code selects the element width for each operation. The result and its valid strobe appear one clock after the input strobe.

Top module: `after_last_extract`

## Requirements
- R1: The size code sets the element width as 8 << code: code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. The element count is VLEN divided by that width. Element i occupies vector bits [i*w +: w].
- R2: All result bits at or above the element width are zero.
- R3: Element i is active exactly when predicate bit i*(w/8) is set. This is the bit at the element's lowest byte. The other predicate bits inside an element have no effect on the result.
- R4: With no active element, the result equals the low w bits of the scalar operand.
- R5: With at least one active element, the result is the element at index (highest active index + 1).
- R6: When the highest active index is the final element, the selected index wraps to zero.
- R7: `res_vld` equals `in_vld` delayed by one clock. `res` carries the result of the operation presented one clock earlier.
- R8: A synchronous active-high reset clears `res_vld` and `res` to zero.
- R9: Active elements below the highest one do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| size | input | 2 | Element size code |
| vec | input | VLEN | Vector operand |
| pred | input | VLEN/8 | Predicate, one bit per byte lane |
| scal | input | 64 | Scalar operand (also the destination) |
| res_vld | output | 1 | Result strobe |
| res | output | 64 | Zero-extended result |

## Verification
A fault in the last-active scan shows up one clock later as a neighbouring element in `res`. A fault in the wrap logic shows up as stale upper lanes instead of lane zero. A wrong width mask leaves nonzero bits above the element size. A missed empty-predicate case returns vector data where the scalar was expected. The sweeps place a single active element at every index for every size, so each of these faults reaches the output within the operation that triggers it.

// File: rtl/after_last_extract.sv
module after_last_extract #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [1:0]        size,
  input  logic [VLEN-1:0]   vec,
  input  logic [VLEN/8-1:0] pred,
  input  logic [63:0]       scal,
  output logic              res_vld,
  output logic [63:0]       res
);
  localparam int NB = VLEN / 8;
  localparam int BW = $clog2(NB) + 1;

  logic          hit;
  logic [BW-1:0] last_b, next_b, step;
  logic [63:0]   emask, picked, res_d;
  logic [VLEN-1:0] shifted;

  always_comb begin
    hit    = 1'b0;
    last_b = '0;
    for (int i = 0; i < NB; i++) begin
      if (pred[i] && ((i & ((1 << size) - 1)) == 0)) begin
        hit    = 1'b1;
        last_b = BW'(i);
      end
    end
  end

  assign step = BW'(1) << size;

  always_comb begin
    next_b = last_b + step;
    if (next_b >= BW'(NB)) next_b = '0;
  end

  assign shifted = vec >> {next_b, 3'b000};
  assign picked  = shifted[63:0];

  always_comb begin
    case (size)
      2'd0:    emask = 64'h0000_0000_0000_00ff;
      2'd1:    emask = 64'h0000_0000_0000_ffff;
      2'd2:    emask = 64'h0000_0000_ffff_ffff;
      default: emask = 64'hffff_ffff_ffff_ffff;
    endcase
  end

  assign res_d = (hit ? picked : scal) & emask;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= in_vld;
      res     <= res_d;
    end
  end
endmodule

// File: rtl/after_last_extract_chk.sv
module after_last_extract_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [1:0]        size,
  input logic [VLEN-1:0]   vec,
  input logic [VLEN/8-1:0] pred,
  input logic [63:0]       scal,
  input logic              res_vld,
  input logic [63:0]       res
);
  localparam int NB = VLEN / 8;

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);
  a_r7_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !res_vld);
  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_vld && size == 2'd0 |=> res[63:8] == '0);
  a_r2_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
    in_vld && size == 2'd1 |=> res[63:16] == '0);
  a_r4_empty_pass: assert property (@(posedge clk) disable iff (rst)
    in_vld && pred == '0 && size == 2'd0 |=> res == {56'd0, $past(scal[7:0])});
  a_r6_byte_wrap: assert property (@(posedge clk) disable iff (rst)
    in_vld && size == 2'd0 && pred[NB-1] |=> res == {56'd0, $past(vec[7:0])});
endmodule

bind after_last_extract after_last_extract_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/test_after_last_extract.sv
`timescale 1ns/1ps
module test_after_last_extract;
  localparam int VLEN = 256;
  localparam int NB = VLEN / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [1:0] size = '0;
  logic [VLEN-1:0] vec = '0;
  logic [NB-1:0] pred = '0;
  logic [63:0] scal = '0;
  logic res_vld;
  logic [63:0] res;

  int checks = 0;
  int errors = 0;
  logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

  always #2 clk = ~clk;

  after_last_extract #(.VLEN(VLEN)) i_after_last_extract (.*);

  function automatic logic [63:0] model(input logic [1:0] sz, input logic [VLEN-1:0] v,
                                        input logic [NB-1:0] p, input logic [63:0] s);
    int eb = 1 << sz;
    int n = NB / eb;
    int last = -1;
    logic [63:0] r;
    logic [63:0] m;
    for (int e = 0; e < n; e++) if (p[e*eb]) last = e;
    if (last < 0) r = s;
    else r = 64'(v >> (((last + 1) % n) * eb * 8));
    m = (sz == 2'd3) ? '1 : ((64'd1 << (8 * eb)) - 64'd1);
    return r & m;
  endfunction

  function automatic logic [63:0] step_lfsr(input logic [63:0] x);
    return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] sz, input logic [VLEN-1:0] v,
                     input logic [NB-1:0] p, input logic [63:0] s);
    logic [63:0] exp;
    exp = model(sz, v, p, s);
    size = sz; vec = v; pred = p; scal = s; in_vld = 1'b1;
    @(negedge clk);
    check({req, " R7 vld"}, {63'd0, res_vld}, 64'd1);
    check(req, res, exp);
  endtask

  function automatic logic [VLEN-1:0] ramp(input int seed);
    logic [VLEN-1:0] v;
    for (int k = 0; k < NB; k++) v[k*8 +: 8] = 8'(k * 7 + 3 + seed);
    return v;
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog got timeout exp done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R8 reset vld", {63'd0, res_vld}, 64'd0);
    check("R8 reset res", res, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 idle vld", {63'd0, res_vld}, 64'd0);

    for (int sz = 0; sz < 4; sz++) begin
      int eb = 1 << sz;
      int n = NB / eb;
      run("R4 empty", 2'(sz), ramp(sz), '0, 64'hfedc_ba98_7654_3210);
      run("R6 all active wrap", 2'(sz), ramp(sz + 1), '1, 64'h1111);
      for (int e = 0; e < n; e++) begin
        logic [NB-1:0] p;
        p = '0; p[e*eb] = 1'b1;
        run((e == n - 1) ? "R6 single last" : "R5 single", 2'(sz), ramp(e), p, 64'hdead_beef_cafe_f00d);
        p = '1 >> (NB - 1 - e * eb);
        run("R9 lower actives", 2'(sz), ramp(e + 5), p, 64'h0);
      end
      if (sz > 0) begin
        logic [NB-1:0] p;
        for (int k = 0; k < NB; k++) p[k] = (k % eb) != 0;
        run("R3 non-lead bits ignored", 2'(sz), ramp(9), p, 64'h0123_4567_89ab_cdef);
      end
      for (int t = 0; t < 200; t++) begin
        logic [VLEN-1:0] v;
        logic [NB-1:0] p;
        for (int w = 0; w < VLEN / 64; w++) begin
          lfsr = step_lfsr(lfsr); v[w*64 +: 64] = lfsr;
        end
        lfsr = step_lfsr(lfsr); p = NB'(lfsr);
        lfsr = step_lfsr(lfsr);
        run("R1 R2 random", 2'(sz), v, p, lfsr);
      end
    end

    in_vld = 1'b0;
    @(negedge clk);
    check("R7 valid drops", {63'd0, res_vld}, 64'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears res", res, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule